// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic core of a small 8-bit accumulator processor. A combinational datapath takes an operation code together with two byte operands, or two 16-bit register-pair operands, and produces a result. It also computes the next value of a flag byte held in a register inside the block. The flag register is written on a clock edge only when the operation is marked valid. Each operation rewrites only the flags it owns, and every flag it owns is written to 0 or 1 on each use; none is merely set.

The flag byte has zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3 down to 0 always read zero. The half-carry is taken out of bit 3 for byte operations and out of bit 11 for pair addition. The operation code is 3 bits wide: 0 byte increment, 1 byte decrement, 2 circular rotate left, 3 circular rotate right, 4 exclusive-OR, 5 pair add, 6 pair increment, 7 pair decrement. Byte operations use `acc_in` as the accumulator operand and `opr_in` as the second operand. Pair operations use `pair_a` and `pair_b`.

Top module: `alu8_core`

## Requirements
- R1: A synchronous active-low reset clears the flag register to 0x00.
- R2: Bits 3..0 of the flag register always read zero.
- R3: Increment (code 0) gives acc_in+1 mod 256. It clears subtract, sets half-carry exactly when acc_in[3:0] is 0xF, sets zero exactly when the result is 0x00, and keeps carry.
- R4: Decrement (code 1) gives acc_in-1 mod 256. It sets subtract, sets half-carry exactly when acc_in[3:0] is 0x0, sets zero exactly when the result is 0x00, and keeps carry.
- R5: Rotate left (code 2) moves acc_in[7] into both result bit 0 and carry. Zero, subtract and half-carry are kept.
- R6: Rotate right (code 3) moves acc_in[0] into both result bit 7 and carry. Zero, subtract and half-carry are kept.
- R7: Exclusive-OR (code 4) gives acc_in^opr_in. It sets zero exactly when that result is 0 and clears subtract, half-carry and carry.
- R8: Pair add (code 5) gives pair_a+pair_b mod 65536. It clears subtract, sets carry exactly on a carry out of bit 15, sets half-carry exactly on a carry out of bit 11, and keeps zero.
- R9: Pair increment (code 6) and pair decrement (code 7) give pair_a+1 and pair_a-1 mod 65536 and leave every flag unchanged.
- R10: The flag register changes only on a clock edge where op_valid is high. Otherwise it holds its value.
- R11: During a byte operation res16 reads 0. During a pair operation res8 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Commit this operation's flags at the next edge |
| op_code | input | 3 | Operation select (codes as listed above) |
| acc_in | input | 8 | Accumulator operand |
| opr_in | input | 8 | Second byte operand (exclusive-OR) |
| pair_a | input | 16 | First register-pair operand |
| pair_b | input | 16 | Second register-pair operand (pair add) |
| res8 | output | 8 | Byte result, combinational |
| res16 | output | 16 | Pair result, combinational |
| flags_q | output | 8 | Registered flag byte |

## Verification
The only state in the block is the flag byte. A wrong value there can be seen directly on flags_q in the cycle after the edge that wrote it. It can also be seen indirectly through the kept bits: a lost carry shows on the next increment, and a corrupted zero shows on the next pair operation. The bench's reference model tracks the flag byte independently and compares it on every clock. A wrong write or a wrong hold is therefore reported within one cycle. A wrong combinational result is reported in the same cycle as the operands that produce it.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag-byte layout for the 8-bit ALU.
// Assumes the flag byte is 8 bits with the four flags in the upper nibble.
package alu8_pkg;

    localparam int FLAG_W = 8;

    typedef enum logic [2:0] {
        OP_INC8  = 3'd0,
        OP_DEC8  = 3'd1,
        OP_RLC   = 3'd2,
        OP_RRC   = 3'd3,
        OP_XOR   = 3'd4,
        OP_ADD16 = 3'd5,
        OP_INC16 = 3'd6,
        OP_DEC16 = 3'd7
    } alu_op_e;

    // Bit order matters: zero at 7, subtract at 6, half-carry at 5, carry at 4.
    typedef struct packed {
        logic       z;
        logic       n;
        logic       h;
        logic       c;
        logic [3:0] rsvd;
    } flags_t;

endpackage

// File: rtl/alu8_byte_unit.sv
// Module: byte-wide operations (increment, decrement, circular rotates, XOR).
// Purely combinational. For operations it does not own, the result is zero
// and the flags pass through unchanged. Reserved flag bits are driven zero.
module alu8_byte_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output flags_t            fout
);

    // Compute the byte result and the flags this operation owns.
    always_comb begin
        res       = '0;
        fout      = fin;
        fout.rsvd = '0;
        unique case (op)
            OP_INC8: begin
                res    = a + DATA_W'(1);
                fout.z = (res == '0);
                fout.n = 1'b0;
                fout.h = (a[NIB_W-1:0] == '1);
            end
            OP_DEC8: begin
                res    = a - DATA_W'(1);
                fout.z = (res == '0);
                fout.n = 1'b1;
                fout.h = (a[NIB_W-1:0] == '0);
            end
            OP_RLC: begin
                res    = {a[DATA_W-2:0], a[DATA_W-1]};
                fout.c = a[DATA_W-1];
            end
            OP_RRC: begin
                res    = {a[0], a[DATA_W-1:1]};
                fout.c = a[0];
            end
            OP_XOR: begin
                res    = a ^ b;
                fout.z = (res == '0);
                fout.n = 1'b0;
                fout.h = 1'b0;
                fout.c = 1'b0;
            end
            default: begin
                res  = '0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_pair_unit.sv
// Module: 16-bit register-pair add, increment and decrement.
// Purely combinational. The half-carry comes from a carry out of bit PAIR_W-5.
// For byte operations the result is zero and the flags pass through.
module alu8_pair_unit
    import alu8_pkg::*;
#(
    parameter int PAIR_W = 16,
    parameter int NIB_W  = 4
) (
    input  alu_op_e           op,
    input  logic [PAIR_W-1:0] a,
    input  logic [PAIR_W-1:0] b,
    input  flags_t            fin,
    output logic [PAIR_W-1:0] res,
    output flags_t            fout
);

    localparam int LOW_W = PAIR_W - NIB_W;

    logic [PAIR_W:0] full_sum;
    logic [LOW_W:0]  low_sum;

    // Full-width and lower-field sums give the carry out of bit 15 and bit 11.
    assign full_sum = {1'b0, a} + {1'b0, b};
    assign low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]};

    // Select the pair result and write the flags pair addition owns.
    always_comb begin
        res       = '0;
        fout      = fin;
        fout.rsvd = '0;
        unique case (op)
            OP_ADD16: begin
                res    = full_sum[PAIR_W-1:0];
                fout.n = 1'b0;
                fout.c = full_sum[PAIR_W];
                fout.h = low_sum[LOW_W];
            end
            OP_INC16: res = a + PAIR_W'(1);
            OP_DEC16: res = a - PAIR_W'(1);
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/alu8_flag_reg.sv
// Module: the flag byte register. Loads on a valid operation and clears on
// synchronous active-low reset. It stores what it is given; keeping the
// reserved bits zero is the job of the units that drive it.
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);

    // Hold the flags; reset clears them, a load replaces them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/alu8_core.sv
// Module: top of the 8-bit ALU. Routes an operation to the byte or pair unit,
// zeroes the result output the operation does not use, and commits the next
// flags when op_valid is high. Assumes op_code and operands are stable
// around the rising clock edge.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opr_in,
    input  logic [PAIR_W-1:0] pair_a,
    input  logic [PAIR_W-1:0] pair_b,
    output logic [DATA_W-1:0] res8,
    output logic [PAIR_W-1:0] res16,
    output logic [FLAG_W-1:0] flags_q
);

    alu_op_e           op;
    logic              is_pair;
    logic [DATA_W-1:0] byte_res;
    logic [PAIR_W-1:0] pair_res;
    flags_t            byte_flags;
    flags_t            pair_flags;
    flags_t            flags_nxt;
    flags_t            flags_cur;

    // Decode the operation and classify it as a byte or a pair operation.
    assign op      = alu_op_e'(op_code);
    assign is_pair = (op == OP_ADD16) || (op == OP_INC16) || (op == OP_DEC16);

    alu8_byte_unit #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_byte (
        .op   (op),
        .a    (acc_in),
        .b    (opr_in),
        .fin  (flags_cur),
        .res  (byte_res),
        .fout (byte_flags)
    );

    alu8_pair_unit #(.PAIR_W(PAIR_W), .NIB_W(NIB_W)) i_pair (
        .op   (op),
        .a    (pair_a),
        .b    (pair_b),
        .fin  (flags_cur),
        .res  (pair_res),
        .fout (pair_flags)
    );

    // Steer results and next flags by operation class.
    always_comb begin
        flags_nxt = is_pair ? pair_flags : byte_flags;
        res8      = is_pair ? '0 : byte_res;
        res16     = is_pair ? pair_res : '0;
    end

    alu8_flag_reg i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_valid),
        .d     (flags_nxt),
        .q     (flags_cur)
    );

    assign flags_q = flags_cur;

    // Reserved flag bits never become nonzero.
    p_low_nibble_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[3:0] == 4'h0);

    // Without a valid operation the flags hold.
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

    // Increment keeps carry and clears subtract.
    p_inc_keeps_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_INC8) |=> (flags_q[4] == $past(flags_q[4])) && !flags_q[6]);

    // Decrement always sets subtract.
    p_dec_sets_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_DEC8) |=> flags_q[6]);

    // Rotate left: old bit 7 lands in carry.
    p_rlc_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_RLC) |=> flags_q[4] == $past(acc_in[DATA_W-1]));

    // Rotate right: old bit 0 lands in carry.
    p_rrc_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_RRC) |=> flags_q[4] == $past(acc_in[0]));

    // Exclusive-OR clears subtract, half-carry and carry.
    p_xor_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_XOR) |=> flags_q[6:4] == 3'b000);

    // Pair add leaves zero alone and clears subtract.
    p_add16_keeps_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ADD16) |=> (flags_q[7] == $past(flags_q[7])) && !flags_q[6]);

    // Pair increment and decrement touch no flag.
    p_pair_step_no_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_INC16 || op == OP_DEC16)) |=> $stable(flags_q));

    // The result output that an operation does not use reads zero.
    p_unused_result_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_pair ? (res8 == '0) : (res16 == '0));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  opr_in = 8'h00;
    logic [15:0] pair_a = 16'h0000;
    logic [15:0] pair_b = 16'h0000;
    logic [7:0]  res8;
    logic [15:0] res16;
    logic [7:0]  flags_q;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    int    mdl_flags = 0;
    string flag_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core i_alu8_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .acc_in   (acc_in),
        .opr_in   (opr_in),
        .pair_a   (pair_a),
        .pair_b   (pair_b),
        .res8     (res8),
        .res16    (res16),
        .flags_q  (flags_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural reference: returns results and next flag byte.
    task automatic model(input int op, input int a, input int b, input int pa, input int pb,
                         input int f, output int r8, output int r16, output int nf);
        int z = (f >> 7) & 1;
        int n = (f >> 6) & 1;
        int h = (f >> 5) & 1;
        int c = (f >> 4) & 1;
        r8 = 0;
        r16 = 0;
        case (op)
            0: begin r8 = (a + 1) % 256; z = (r8 == 0); n = 0; h = ((a % 16) == 15); end
            1: begin r8 = (a + 255) % 256; z = (r8 == 0); n = 1; h = ((a % 16) == 0); end
            2: begin r8 = ((a * 2) % 256) + (a / 128); c = a / 128; end
            3: begin r8 = (a / 2) + ((a % 2) * 128); c = a % 2; end
            4: begin r8 = a ^ b; z = (r8 == 0); n = 0; h = 0; c = 0; end
            5: begin
                r16 = (pa + pb) % 65536;
                c = ((pa + pb) > 65535);
                h = (((pa % 4096) + (pb % 4096)) > 4095);
                n = 0;
            end
            6: r16 = (pa + 1) % 65536;
            default: r16 = (pa + 65535) % 65536;
        endcase
        nf = z * 128 + n * 64 + h * 32 + c * 16;
    endtask

    // One cycle: drive, compare every output against the model, advance the model.
    task automatic step(input bit v, input int op, input int a, input int b, input int pa, input int pb);
        int r8, r16, nf;
        string t;
        @(negedge clk);
        op_valid = v;
        op_code  = 3'(op);
        acc_in   = 8'(a);
        opr_in   = 8'(b);
        pair_a   = 16'(pa);
        pair_b   = 16'(pb);
        #1;
        model(op, a, b, pa, pb, mdl_flags, r8, r16, nf);
        t = op_tag(op);
        chk(flag_tag, "flags", int'(flags_q), mdl_flags);
        chk("R2", "flag low nibble", int'(flags_q[3:0]), 0);
        if (op >= 5) begin
            chk(t, "res16", int'(res16), r16);
            chk("R11", "res8 unused", int'(res8), 0);
        end else begin
            chk(t, "res8", int'(res8), r8);
            chk("R11", "res16 unused", int'(res16), 0);
        end
        if (v) begin
            mdl_flags = nf;
            flag_tag = t;
        end else begin
            flag_tag = "R10";
        end
    endtask

    task automatic reset_now();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b1;
        op_code = 3'd1;
        acc_in = 8'h00;
        @(negedge clk);
        #1;
        chk("R1", "flags after reset", int'(flags_q), 0);
        rst_n = 1'b1;
        op_valid = 1'b0;
        mdl_flags = 0;
        flag_tag = "R1";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "flags at reset", int'(flags_q), 0);
        rst_n = 1'b1;
        // R3 corner cases: wrap to zero, nibble carry, plain step.
        step(1, 0, 8'hFF, 0, 0, 0);
        step(1, 0, 8'h0F, 0, 0, 0);
        step(1, 0, 8'h41, 0, 0, 0);
        // R4: borrow from 0x00 and 0x10, result zero from 0x01.
        step(1, 1, 8'h00, 0, 0, 0);
        step(1, 1, 8'h10, 0, 0, 0);
        step(1, 1, 8'h01, 0, 0, 0);
        // R5 and R6: rotates with the carry bit set and clear.
        step(1, 2, 8'h80, 0, 0, 0);
        step(1, 2, 8'h41, 0, 0, 0);
        step(1, 3, 8'h01, 0, 0, 0);
        step(1, 3, 8'h82, 0, 0, 0);
        // R3: increment keeps the carry left by a rotate.
        step(1, 2, 8'h80, 0, 0, 0);
        step(1, 0, 8'h22, 0, 0, 0);
        // R7: self-cancel and a nonzero result.
        step(1, 4, 8'h5A, 8'h5A, 0, 0);
        step(1, 4, 8'h5A, 8'h0F, 0, 0);
        // R8: full wrap, bit-11 carry only, no carry, zero kept.
        step(1, 1, 8'h01, 0, 0, 0);
        step(1, 5, 0, 0, 16'hFFFF, 16'h0001);
        step(1, 5, 0, 0, 16'h0800, 16'h0800);
        step(1, 5, 0, 0, 16'h1234, 16'h0101);
        // R9: pair steps wrap and keep flags.
        step(1, 2, 8'h80, 0, 0, 0);
        step(1, 6, 0, 0, 16'hFFFF, 0);
        step(1, 7, 0, 0, 16'h0000, 0);
        step(1, 7, 0, 0, 16'h1000, 0);
        // R10: operations presented without op_valid leave flags alone.
        step(0, 4, 8'h33, 8'h33, 0, 0);
        step(0, 0, 8'hFF, 0, 0, 0);
        step(0, 5, 0, 0, 16'hFFFF, 16'hFFFF);
        step(1, 0, 8'h00, 0, 0, 0);
        // R1: reset while a valid operation is presented.
        step(1, 3, 8'h01, 0, 0, 0);
        reset_now();
        step(0, 0, 0, 0, 0, 0);
        // Mixed random traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 256),
                 int'($urandom % 256), int'($urandom % 65536), int'($urandom % 65536));
        end
        step(0, 0, 0, 0, 0, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule